// File: doc/BRIEF.md
# Cache maintenance command engine

This block carries out maintenance operations on the state bits of a small set-associative cache pair: an instruction cache and a data cache. Each cache has 4 ways of 64 sets with 16-byte lines. For every line the block keeps a valid bit, a dirty bit and a tag. The block does not hold line data and has no normal lookup or refill path. Software programs it through a narrow register write port. It writes the low and high halves of a start address, a line count and then a command word. A command with its start bit set launches a walk over the requested lines. The walk updates the state bits of each line and, for the data cache, asks for line writebacks on a valid/ready port.

Two addressing modes exist. In range mode each line address in the range is looked up, and the operation applies to whichever way holds that line. In way-select mode the operation applies to the named way at each set index, whatever tag is stored there. The whole-way clear ignores the address and count. It always walks all 64 sets of the named way.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset `busy`, `err` and `wb_valid` are 0, and every line of both caches is invalid.
- R2: Register selects are 0 for address low, 1 for address high, 2 for count and 3 for command. The command word places the op code in bits 2:0, the cache select in bit 3 (1 = data, 0 = instruction), the way in bits 5:4, way-select enable in bit 6 and start in bit 7. A command write with bit 7 set while idle raises `busy` in the next cycle. A command write with bit 7 clear does nothing.
- R3: The count register holds the number of lines minus one. Lines start at the 16-byte aligned start address and step by 16 bytes. The set index is address bits 9:4 and the tag is bits 31:10. A walk with no writebacks keeps `busy` high for exactly count+1 cycles.
- R4: Op 111 (mark dirty) and op 101 (fill) allocate on a range-mode miss into the lowest-numbered invalid way. Mark dirty leaves the line valid and dirty. Fill leaves it valid and clean. A miss with no free way changes nothing. A fill that hits changes nothing. A mark dirty that hits sets the dirty bit.
- R5: Op 000 requests a writeback for each selected valid, dirty data line and leaves the line clean.
- R6: Op 001 requests a writeback for each selected valid data line and leaves the line clean.
- R7: Op 011 requests a writeback for each selected valid data line, then invalidates it.
- R8: Op 110 invalidates the selected lines without any writeback.
- R9: Op 100 invalidates all 64 sets of the way in bits 5:4, ignoring address, count and bit 6. It takes 64 cycles and leaves the other ways untouched.
- R10: In way-select mode the operation applies only to the named way at each set. A writeback then reports the stored tag and the set as its address, and reports that way on `wb_way`.
- R11: A start command with reserved op 010 sets `err`, does not raise `busy` and changes no state. The next accepted start clears `err`.
- R12: Command writes while `busy` is high are ignored.
- R13: Operations on the instruction cache never request writebacks and never change data cache state.
- R14: While `wb_valid` is high and `wb_ready` is low, the engine stalls. During the stall `wb_valid`, `wb_addr` and `wb_way` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| busy | output | 1 | Walk in progress |
| err | output | 1 | Reserved op code was launched |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_addr | output | 32 | Line-aligned address to write back |
| wb_way | output | 2 | Way holding the line to write back |

## Verification
A corrupted valid, dirty or tag bit inside the engine does not show when it happens. It shows on the next sync walk that covers that line, as a missing writeback, an extra writeback or a wrong address or way. So every state-changing operation is followed by a sync-if-valid or sync-if-dirty walk over the same lines. Every request is compared against a scoreboard built from a reference model. Pacing faults show at once, as a `busy` window of the wrong length or a request that moves while `wb_ready` is low.

// File: rtl/cme_pkg.sv
package cme_pkg;
    localparam int ADDR_W     = 32;
    localparam int REG_W      = 16;
    localparam int CNT_W      = 16;
    localparam int LINE_BYTES = 16;
    localparam int SETS       = 64;
    localparam int WAYS       = 4;
    localparam int CACHES     = 2;

    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int TAG_W  = LINE_W - IDX_W;

    typedef enum logic [2:0] {
        OP_SYNC_DIRTY = 3'b000,
        OP_SYNC_VALID = 3'b001,
        OP_RSVD       = 3'b010,
        OP_SYNC_INV   = 3'b011,
        OP_WAY_CLR    = 3'b100,
        OP_FILL       = 3'b101,
        OP_INVAL      = 3'b110,
        OP_MARK_DIRTY = 3'b111
    } maint_op_e;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_CMD     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             go;
        logic             way_en;
        logic [WAY_W-1:0] way;
        logic             dsel;
        maint_op_e        op;
    } cmd_t;

    typedef struct packed {
        logic             en;
        logic             dsel;
        logic [IDX_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic             valid;
        logic             dirty;
        logic             tag_we;
        logic [TAG_W-1:0] tag;
    } upd_t;

    function automatic logic [WAY_W-1:0] low_way(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (v[w]) r = WAY_W'(w);
        end
        return r;
    endfunction
endpackage

// File: rtl/cme_regs.sv
module cme_regs
    import cme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              busy,
    output logic              launch,
    output cmd_t              launch_cmd,
    output logic [LINE_W-1:0] start_line,
    output logic [CNT_W-1:0]  count,
    output logic              err
);
    logic [REG_W-1:0]  addr_lo_q, addr_hi_q;
    logic [ADDR_W-1:0] full_addr;
    logic              cmd_wr, go_req;

    assign full_addr  = {addr_hi_q, addr_lo_q};
    assign start_line = full_addr[ADDR_W-1:OFS_W];
    assign cmd_wr     = cfg_we && (reg_sel_e'(cfg_sel) == SEL_CMD);
    assign launch_cmd = cmd_t'(cfg_wdata[$bits(cmd_t)-1:0]);
    assign go_req     = cmd_wr && launch_cmd.go && !busy;
    assign launch     = go_req && (launch_cmd.op != OP_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            count     <= '0;
            err       <= 1'b0;
        end else begin
            if (cfg_we && reg_sel_e'(cfg_sel) == SEL_ADDR_LO) addr_lo_q <= cfg_wdata;
            if (cfg_we && reg_sel_e'(cfg_sel) == SEL_ADDR_HI) addr_hi_q <= cfg_wdata;
            if (cfg_we && reg_sel_e'(cfg_sel) == SEL_COUNT)   count     <= cfg_wdata[CNT_W-1:0];
            if (go_req) err <= (launch_cmd.op == OP_RSVD);
        end
    end
endmodule

// File: rtl/cme_state.sv
module cme_state
    import cme_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_dsel,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  upd_t                        upd
);
    logic [CACHES-1:0][WAYS-1:0]             v_all;
    logic [CACHES-1:0][WAYS-1:0]             d_all;
    logic [CACHES-1:0][WAYS-1:0][TAG_W-1:0]  t_all;

    for (genvar c = 0; c < CACHES; c++) begin : g_cache
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [SETS-1:0]  vld;
            logic [SETS-1:0]  drt;
            logic [TAG_W-1:0] tags [SETS];
            logic             hit_me;

            assign hit_me = upd.en && (int'(upd.dsel) == c) && (int'(upd.way) == w);

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld <= '0;
                    drt <= '0;
                end else if (hit_me) begin
                    vld[upd.set] <= upd.valid;
                    drt[upd.set] <= upd.dirty;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst && hit_me && upd.tag_we) tags[upd.set] <= upd.tag;
            end

            assign v_all[c][w] = vld[rd_set];
            assign d_all[c][w] = drt[rd_set];
            assign t_all[c][w] = tags[rd_set];
        end
    end

    assign rd_valid = v_all[rd_dsel];
    assign rd_dirty = d_all[rd_dsel];
    assign rd_tag   = t_all[rd_dsel];
endmodule

// File: rtl/cme_walker.sv
module cme_walker
    import cme_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        launch,
    input  cmd_t                        launch_cmd,
    input  logic [LINE_W-1:0]           start_line,
    input  logic [CNT_W-1:0]            count,
    input  logic [WAYS-1:0]             rd_valid,
    input  logic [WAYS-1:0]             rd_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic                        wb_ready,
    output logic                        busy,
    output logic                        wb_valid,
    output logic [ADDR_W-1:0]           wb_addr,
    output logic [WAY_W-1:0]            wb_way,
    output logic                        rd_dsel,
    output logic [IDX_W-1:0]            rd_set,
    output upd_t                        upd
);
    logic              run_q, dsel_q, wayen_q;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  remain_q;
    logic [WAY_W-1:0]  way_q;
    maint_op_e         op_q;

    logic [TAG_W-1:0]  cur_tag;
    logic [WAYS-1:0]   hit_vec, free_vec;
    logic              hit, alloc_op, tgt_ok, need_wb, advance;
    logic [WAY_W-1:0]  tgt;
    logic              tv, td;
    upd_t              nxt;

    assign rd_set  = line_q[IDX_W-1:0];
    assign rd_dsel = dsel_q;
    assign cur_tag = line_q[LINE_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w]  = rd_valid[w] && (rd_tag[w] == cur_tag);
        assign free_vec[w] = !rd_valid[w];
    end

    assign hit      = |hit_vec;
    assign alloc_op = (op_q == OP_FILL) || (op_q == OP_MARK_DIRTY);

    always_comb begin
        tgt    = way_q;
        tgt_ok = 1'b0;
        if (wayen_q) begin
            tgt_ok = 1'b1;
        end else if (hit) begin
            tgt    = low_way(hit_vec);
            tgt_ok = 1'b1;
        end else if (alloc_op && |free_vec) begin
            tgt    = low_way(free_vec);
            tgt_ok = 1'b1;
        end
    end

    assign tv = rd_valid[tgt];
    assign td = rd_dirty[tgt];

    always_comb begin
        need_wb    = 1'b0;
        nxt.en     = 1'b0;
        nxt.dsel   = dsel_q;
        nxt.set    = rd_set;
        nxt.way    = tgt;
        nxt.valid  = tv;
        nxt.dirty  = td;
        nxt.tag_we = 1'b0;
        nxt.tag    = cur_tag;
        if (tgt_ok) begin
            case (op_q)
                OP_SYNC_DIRTY: if (tv && td && dsel_q) begin
                    need_wb   = 1'b1;
                    nxt.en    = 1'b1;
                    nxt.dirty = 1'b0;
                end
                OP_SYNC_VALID: if (tv && dsel_q) begin
                    need_wb   = 1'b1;
                    nxt.en    = 1'b1;
                    nxt.dirty = 1'b0;
                end
                OP_SYNC_INV: if (tv) begin
                    need_wb   = dsel_q;
                    nxt.en    = 1'b1;
                    nxt.valid = 1'b0;
                    nxt.dirty = 1'b0;
                end
                OP_WAY_CLR, OP_INVAL: begin
                    nxt.en    = 1'b1;
                    nxt.valid = 1'b0;
                    nxt.dirty = 1'b0;
                end
                OP_FILL: if (wayen_q || !hit) begin
                    nxt.en     = 1'b1;
                    nxt.valid  = 1'b1;
                    nxt.dirty  = 1'b0;
                    nxt.tag_we = 1'b1;
                end
                OP_MARK_DIRTY: begin
                    nxt.en     = 1'b1;
                    nxt.valid  = 1'b1;
                    nxt.dirty  = dsel_q;
                    nxt.tag_we = wayen_q || !hit;
                end
                default: ;
            endcase
        end
    end

    assign wb_valid = run_q && need_wb;
    assign advance  = run_q && (!need_wb || wb_ready);
    assign wb_addr  = {rd_tag[tgt], rd_set, {OFS_W{1'b0}}};
    assign wb_way   = tgt;
    assign busy     = run_q;

    always_comb begin
        upd    = nxt;
        upd.en = nxt.en && advance;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            line_q   <= '0;
            remain_q <= '0;
            op_q     <= OP_SYNC_DIRTY;
            dsel_q   <= 1'b0;
            way_q    <= '0;
            wayen_q  <= 1'b0;
        end else if (launch && !run_q) begin
            run_q  <= 1'b1;
            op_q   <= launch_cmd.op;
            dsel_q <= launch_cmd.dsel;
            way_q  <= launch_cmd.way;
            if (launch_cmd.op == OP_WAY_CLR) begin
                line_q   <= '0;
                remain_q <= CNT_W'(SETS - 1);
                wayen_q  <= 1'b1;
            end else begin
                line_q   <= start_line;
                remain_q <= count;
                wayen_q  <= launch_cmd.way_en;
            end
        end else if (advance) begin
            if (remain_q == '0) begin
                run_q <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
                line_q   <= line_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import cme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              busy,
    output logic              err,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WAY_W-1:0]  wb_way
);
    logic                        launch;
    cmd_t                        launch_cmd;
    logic [LINE_W-1:0]           start_line;
    logic [CNT_W-1:0]            count;
    logic                        act_dsel;
    logic [IDX_W-1:0]            rd_set;
    logic [WAYS-1:0]             rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    upd_t                        upd;

    cme_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .launch(launch),
        .launch_cmd(launch_cmd), .start_line(start_line), .count(count),
        .err(err)
    );

    cme_walker u_walk (
        .clk(clk), .rst(rst), .launch(launch), .launch_cmd(launch_cmd),
        .start_line(start_line), .count(count), .rd_valid(rd_valid),
        .rd_dirty(rd_dirty), .rd_tag(rd_tag), .wb_ready(wb_ready),
        .busy(busy), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_way(wb_way),
        .rd_dsel(act_dsel), .rd_set(rd_set), .upd(upd)
    );

    cme_state u_state (
        .clk(clk), .rst(rst), .rd_dsel(act_dsel), .rd_set(rd_set),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .upd(upd)
    );
endmodule

// File: rtl/cme_checker.sv
module cme_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic [15:0] cfg_wdata,
    input logic        busy,
    input logic        err,
    input logic        wb_valid,
    input logic        wb_ready,
    input logic [31:0] wb_addr,
    input logic [1:0]  wb_way,
    input logic        act_dsel
);
    logic start_wr;
    assign start_wr = cfg_we && (cfg_sel == 2'd3) && cfg_wdata[7] && !busy;

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_way)); // R14

    AST_WB_WITHIN_WALK: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> busy); // R2

    AST_ICACHE_SILENT: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> act_dsel); // R13

    AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        start_wr && cfg_wdata[2:0] == 3'b010 |=> err && !busy); // R11

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_wr && cfg_wdata[2:0] != 3'b010 |=> busy && !err); // R2
endmodule

bind cache_maint_engine cme_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .err(err), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_way(wb_way),
    .act_dsel(act_dsel)
);

// File: tb/tb_cache_maint_engine.sv
module tb_cache_maint_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        busy, err, wb_valid;
    logic        wb_ready = 1'b0;
    logic [31:0] wb_addr;
    logic [1:0]  wb_way;

    int n_chk = 0;
    int n_fail = 0;
    bit stall = 0;
    int tick = 0;
    bit hold_chk = 0;
    logic [31:0] held_addr;
    logic [1:0]  held_way;
    string cur_req = "R1";

    typedef struct { logic [31:0] a; logic [1:0] w; } wb_t;
    wb_t exq[$];

    bit          mv [2][4][64];
    bit          md [2][4][64];
    logic [21:0] mt [2][4][64];

    cache_maint_engine dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .err(err), .wb_valid(wb_valid),
        .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_way(wb_way)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: drives ready, checks stall stability and pops the scoreboard
    always @(negedge clk) begin
        bit rdy;
        if (rst) begin
            wb_ready = 1'b0;
            hold_chk = 0;
        end else begin
            rdy = stall ? (tick % 3 == 2) : 1'b1;
            tick++;
            if (hold_chk)
                check(wb_valid && wb_addr == held_addr && wb_way == held_way, "R14",
                      {31'd0, wb_valid, wb_addr}, {32'd1, held_addr});
            hold_chk = wb_valid && !rdy;
            held_addr = wb_addr;
            held_way = wb_way;
            if (wb_valid && rdy) begin
                if (exq.size() == 0) begin
                    check(0, cur_req, {30'd0, wb_way, wb_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    wb_t e;
                    e = exq.pop_front();
                    check(wb_addr == e.a && wb_way == e.w, cur_req,
                          {30'd0, wb_way, wb_addr}, {30'd0, e.w, e.a});
                end
            end
            wb_ready = rdy;
        end
    end

    task automatic model(input int op, input int d, input int way, input bit wen,
                         input logic [31:0] addr, input int cnt);
        int n;
        logic [27:0] ln;
        bit wm;
        wm = wen;
        if (op == 4) begin wm = 1; ln = '0; n = 64; end
        else begin ln = addr[31:4]; n = cnt + 1; end
        for (int i = 0; i < n; i++) begin
            int s;
            int t;
            bit hit;
            logic [21:0] tg;
            s = int'(ln[5:0]);
            tg = ln[27:6];
            t = -1;
            hit = 0;
            if (wm) t = way;
            else begin
                for (int w = 3; w >= 0; w--)
                    if (mv[d][w][s] && mt[d][w][s] == tg) begin t = w; hit = 1; end
                if (t < 0 && (op == 5 || op == 7))
                    for (int w = 3; w >= 0; w--) if (!mv[d][w][s]) t = w;
            end
            if (t >= 0) begin
                wb_t e;
                e.a = {mt[d][t][s], 6'(s), 4'd0};
                e.w = 2'(t);
                case (op)
                    0: if (mv[d][t][s] && md[d][t][s] && d == 1) begin exq.push_back(e); md[d][t][s] = 0; end
                    1: if (mv[d][t][s] && d == 1) begin exq.push_back(e); md[d][t][s] = 0; end
                    3: if (mv[d][t][s]) begin
                           if (d == 1) exq.push_back(e);
                           mv[d][t][s] = 0; md[d][t][s] = 0;
                       end
                    4, 6: begin mv[d][t][s] = 0; md[d][t][s] = 0; end
                    5: if (wm || !hit) begin mv[d][t][s] = 1; md[d][t][s] = 0; mt[d][t][s] = tg; end
                    7: begin
                           if (wm || !hit) mt[d][t][s] = tg;
                           mv[d][t][s] = 1;
                           md[d][t][s] = (d == 1);
                       end
                    default: ;
                endcase
            end
            ln++;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] cmdw(input bit go, input int op, input int d, input int way, input bit wen);
        return {8'h00, go, wen, 2'(way), 1'(d), 3'(op)};
    endfunction

    task automatic run(input int op, input int d, input int way, input bit wen,
                       input logic [31:0] addr, input int cnt, input string req, input int exp_cyc);
        int cyc;
        cur_req = req;
        model(op, d, way, wen, addr, cnt);
        wr(2'd0, addr[15:0]);
        wr(2'd1, addr[31:16]);
        wr(2'd2, 16'(cnt));
        wr(2'd3, cmdw(1, op, d, way, wen));
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
        if (exp_cyc >= 0) check(cyc == exp_cyc, req, 64'(cyc), 64'(exp_cyc));
        check(exq.size() == 0, req, 64'(exq.size()), 64'd0);
        exq.delete();
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", 64'(busy), 0);
        check(err == 0, "R1", 64'(err), 0);
        check(wb_valid == 0, "R1", 64'(wb_valid), 0);
        run(1, 1, 0, 0, 32'h0, 63, "R1", 64);
        // R4 allocation
        run(7, 1, 0, 0, 32'h1000, 3, "R4", 4);
        run(5, 1, 0, 0, 32'h2000, 1, "R4", 2);
        // R5 with stalling ready (R14 checked in monitor)
        stall = 1;
        run(0, 1, 0, 0, 32'h1000, 7, "R5", -1);
        stall = 0;
        run(0, 1, 0, 0, 32'h1000, 7, "R5", 8);
        // R6
        run(1, 1, 0, 0, 32'h2000, 1, "R6", -1);
        // R10 way-select mode
        run(7, 1, 2, 1, 32'h3000, 0, "R10", 1);
        run(0, 1, 2, 1, 32'h0000, 0, "R10", -1);
        // R7
        run(3, 1, 0, 0, 32'h1000, 0, "R7", -1);
        run(1, 1, 0, 0, 32'h1000, 0, "R7", 1);
        // R8
        run(6, 1, 0, 0, 32'h2000, 0, "R8", 1);
        run(1, 1, 0, 0, 32'h2000, 0, "R8", 1);
        // R9 whole-way clear
        run(7, 1, 3, 1, 32'h4050, 0, "R9", 1);
        run(4, 1, 3, 1, 32'h4050, 0, "R9", 64);
        run(1, 1, 3, 1, 32'h0000, 63, "R9", 64);
        run(1, 1, 0, 0, 32'h2010, 0, "R9", -1);
        // R3 count length
        run(6, 1, 0, 0, 32'h7000, 9, "R3", 10);
        // R11 reserved code
        wr(2'd3, cmdw(1, 2, 1, 0, 0));
        check(err == 1, "R11", 64'(err), 1);
        check(busy == 0, "R11", 64'(busy), 0);
        run(1, 1, 0, 0, 32'h1010, 0, "R11", -1);
        check(err == 0, "R11", 64'(err), 0);
        // R12 command ignored while busy
        cur_req = "R12";
        model(4, 1, 0, 1, 32'h0, 0);
        wr(2'd0, 16'h0); wr(2'd1, 16'h0); wr(2'd2, 16'h0);
        wr(2'd3, cmdw(1, 4, 1, 0, 1));
        wr(2'd3, cmdw(1, 7, 1, 1, 1));
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
        check(cyc == 62, "R12", 64'(cyc), 62);
        run(0, 1, 1, 1, 32'h0, 63, "R12", 64);
        // R13 instruction cache
        run(7, 0, 0, 0, 32'h2010, 3, "R13", 4);
        run(1, 0, 0, 0, 32'h2010, 3, "R13", 4);
        run(3, 0, 0, 0, 32'h2010, 3, "R13", 4);
        run(1, 1, 1, 0, 32'h2010, 0, "R13", -1);
        // R2 command without start bit
        wr(2'd3, cmdw(0, 7, 1, 0, 0));
        check(busy == 0, "R2", 64'(busy), 0);
        run(0, 1, 0, 0, 32'h2010, 0, "R2", 1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule